// File: doc/BRIEF.md
# Five-Bit Word Serializer with Run-Time Bit Order

This block converts a stream of 5-bit parallel words into a single serial bit stream at five times the word rate. The parallel clock and the serial clock are modelled as one fast clock. An internal slot timer raises a load tick once every five cycles, and each tick samples the parallel input. The host places a word on the bus and asserts valid in the cycle where the load tick is high. Over the next five cycles the block sends that word out one bit per cycle. A strobe marks the first bit of every word slot.

A 10-bit symbol travels as two consecutive words. When the host presents the lower half first, the symbol leaves least significant bit first. A run-time order input chooses the bit order within each word: lane 0 first, or lane 4 first. The block reads that input only at the load tick, so a change takes effect at the next word boundary. If valid is low at a load tick, the block sends five zero bits. It does not repeat the previous word.

The slot timer has two states. `ST_PRIME` is the single cycle right after reset. It always moves to `ST_RUN` (transition *kickoff*). `ST_RUN` stays in `ST_RUN` and counts bit positions 0 to 4. Leaving position 4, it wraps to position 0 (transition *next_slot*). A load tick occurs in `ST_PRIME` and at position 4 of `ST_RUN`.

Top module: `ser5_serializer`

## Requirements
- R1: In the cycle after reset, `ser_out` and `word_start` are 0 and `load_tick` is 1.
- R2: Once running, `load_tick` is high in exactly one cycle out of every five, with no gap between word slots.
- R3: With `msb_lane_first`=0 at the load tick, the loaded word leaves in the order bit 0, 1, 2, 3, 4. Bit 0 appears in the cycle after the load tick.
- R4: With `msb_lane_first`=1 at the load tick, the loaded word leaves in the order bit 4, 3, 2, 1, 0.
- R5: Suppose a 10-bit symbol S is presented as S[4:0] followed by S[9:5], both with `msb_lane_first`=0. Then its bits leave in the order S[0] through S[9] on ten consecutive cycles.
- R6: If `in_vld` is 0 at a load tick, the next five serial bits are 0 whatever `in_word` holds.
- R7: A change of `msb_lane_first` between load ticks does not alter the order of the word being sent.
- R8: `word_start` is 1 exactly in the cycle that carries the first bit of a word slot. That is the cycle after each load tick.
- R9: Pulling `rst_n` low, a synchronous and active-low reset, in the middle of a word drops the remaining bits. The block then restarts at R1 behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (bit-rate) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Parallel word valid, sampled at load tick |
| in_word | input | 5 | Parallel word, lane i on bit i |
| msb_lane_first | input | 1 | 1: lane 4 sent first; 0: lane 0 sent first |
| load_tick | output | 1 | High in the cycle whose edge samples the input |
| ser_out | output | 1 | Serial data bit |
| word_start | output | 1 | High on the first bit of each word slot |

## Verification
Suppose the bit counter drifts or skips a value. Then the spacing of `load_tick` breaks at once, and every later word comes out rotated within one word time. An order flag latched at the wrong moment reverses a word within five cycles. A shift register that is not cleared shows up as stale ones in a zero-filled slot. The bench compares every serial bit and every strobe against a queue of expected bits. Any such fault therefore appears within one word slot of its cause.

// File: rtl/ser5_pkg.sv
package ser5_pkg;
    typedef enum logic {
        ST_PRIME = 1'b0,
        ST_RUN   = 1'b1
    } slot_state_t;
endpackage

// File: rtl/ser5_slot_timer.sv
module ser5_slot_timer
    import ser5_pkg::*;
#(
    parameter int WORD_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic take,
    output logic first_bit
);
    localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

    slot_state_t state_q, state_d;
    logic [CW-1:0] pos_q, pos_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            pos_q   <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        pos_d     = pos_q;
        take      = 1'b0;
        first_bit = 1'b0;
        unique case (state_q)
            ST_PRIME: begin
                take    = 1'b1;
                state_d = ST_RUN;      // kickoff
                pos_d   = '0;
            end
            ST_RUN: begin
                first_bit = (pos_q == '0);
                if (pos_q == LAST) begin
                    take  = 1'b1;
                    pos_d = '0;        // next_slot
                end else begin
                    pos_d = pos_q + 1'b1;
                end
            end
            default: state_d = ST_PRIME;
        endcase
    end

    AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST) else $error("position out of range"); // R2
endmodule

// File: rtl/ser5_shift_reg.sv
module ser5_shift_reg #(
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              vld,
    input  logic [WORD_W-1:0] word,
    input  logic              rev,
    output logic              ser
);
    logic [WORD_W-1:0] oriented;
    logic [WORD_W-1:0] sh_q;

    for (genvar i = 0; i < WORD_W; i++) begin : g_orient
        assign oriented[i] = rev ? word[WORD_W-1-i] : word[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            sh_q <= '0;
        else if (load)
            sh_q <= vld ? oriented : '0;
        else
            sh_q <= sh_q >> 1;
    end

    assign ser = sh_q[0];

    AST_LANE0_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && vld && !rev) |=> (ser == $past(word[0]))) else $error("lane 0 not first"); // R3
    AST_LANE4_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && vld && rev) |=> (ser == $past(word[WORD_W-1]))) else $error("lane 4 not first"); // R4
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !vld) |=> (sh_q == '0)) else $error("stale word repeated"); // R6
endmodule

// File: rtl/ser5_serializer.sv
module ser5_serializer #(
    parameter int WORD_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] in_word,
    input  logic              msb_lane_first,
    output logic              load_tick,
    output logic              ser_out,
    output logic              word_start
);
    logic take;
    logic first_bit;

    ser5_slot_timer #(.WORD_W(WORD_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (take),
        .first_bit (first_bit)
    );

    ser5_shift_reg #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (take),
        .vld   (in_vld),
        .word  (in_word),
        .rev   (msb_lane_first),
        .ser   (ser_out)
    );

    assign load_tick  = take;
    assign word_start = first_bit;

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !take) else $error("back-to-back load"); // R2
    AST_START_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> first_bit) else $error("start strobe missing"); // R8
endmodule

// File: tb/sim_ser5_serializer.sv
module sim_ser5_serializer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic [4:0] in_word = '0;
    logic msb_lane_first = 1'b0;
    logic load_tick, ser_out, word_start;

    int n_chk = 0;
    int n_bad = 0;

    logic [1:0] exp_q[$];   // {start, bit}
    string      tag_q[$];

    always #10 clk = ~clk;   // 50 MHz

    ser5_serializer u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_word(in_word),
        .msb_lane_first(msb_lane_first), .load_tick(load_tick),
        .ser_out(ser_out), .word_start(word_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] rev5(input logic [4:0] w);
        for (int i = 0; i < 5; i++) rev5[i] = w[4-i];
    endfunction

    // driver: waits for a load tick, drives the word, queues expected bits
    task automatic send(input bit v, input logic [4:0] w, input bit r,
                        input bit flip, input logic [4:0] exp, input string tag);
        @(negedge clk);
        while (!load_tick) @(negedge clk);
        in_vld = v; in_word = w; msb_lane_first = r;
        for (int i = 0; i < 5; i++) begin
            exp_q.push_back({(i == 0), exp[i]});
            tag_q.push_back(tag);
        end
        if (flip) begin
            repeat (2) @(negedge clk);
            msb_lane_first = ~msb_lane_first;  // R7: mid-word change
        end
    endtask

    // monitor: compares each cycle's bit and strobe
    logic [1:0] e;
    string t;
    always @(posedge clk) begin
        #1;
        if (rst_n && exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(ser_out == e[0], {t, " bit"}, ser_out, e[0]);
            chk(word_start == e[1], "R8 word_start", word_start, e[1]);
        end
    end

    // load tick spacing
    int gap = 0;
    bit seen = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            gap = 0; seen = 0;
        end else if (load_tick) begin
            if (seen) chk(gap == 5, "R2 tick spacing", gap, 5);
            seen = 1; gap = 1;
        end else begin
            gap++;
        end
    end

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] sym;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ser_out == 1'b0, "R1 ser_out", ser_out, 0);
        chk(word_start == 1'b0, "R1 word_start", word_start, 0);
        chk(load_tick == 1'b1, "R1 load_tick", load_tick, 1);

        send(1, 5'b10110, 0, 0, 5'b10110, "R3");
        send(1, 5'b00001, 0, 0, 5'b00001, "R3");
        send(1, 5'b10110, 1, 0, rev5(5'b10110), "R4");
        send(1, 5'b00001, 1, 0, rev5(5'b00001), "R4");
        sym = 10'b1101001110;
        send(1, sym[4:0], 0, 0, sym[4:0], "R5");
        send(1, sym[9:5], 0, 0, sym[9:5], "R5");
        send(1, 5'b11111, 0, 0, 5'b11111, "R6");
        send(0, 5'b10110, 0, 0, 5'b00000, "R6");
        send(1, 5'b00011, 0, 1, 5'b00011, "R7");
        send(1, 5'b00011, 1, 1, rev5(5'b00011), "R7");

        // R9: reset in the middle of a word
        send(1, 5'b11111, 0, 0, 5'b11111, "R9");
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        exp_q.delete();
        tag_q.delete();
        repeat (2) @(negedge clk);
        #1;
        chk(ser_out == 1'b0, "R9 ser_out", ser_out, 0);
        chk(word_start == 1'b0, "R9 word_start", word_start, 0);
        chk(load_tick == 1'b1, "R9 load_tick", load_tick, 1);
        @(negedge clk);
        rst_n = 1'b1;

        for (int k = 0; k < 8; k++) begin
            logic [4:0] w;
            w = 5'(k * 7 + 3);
            if (k % 2 == 0) send(1, w, 0, 0, w, "R3");
            else            send(1, w, 1, 0, rev5(w), "R4");
        end
        send(0, 5'b11111, 0, 0, 5'b00000, "R6");

        repeat (8) @(negedge clk);
        chk(exp_q.size() == 0, "R3 queue drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule